// File: doc/BRIEF.md
# Per-Region Bus Wait-State Controller

This block sets the timing of each access made by an 8-bit external bus master that drives a 24-bit address. The address space is divided into eight regions of 2 MB each. Each region has two configuration bits. One bit chooses a short access of two cycles or a long access of three cycles. The other bit allows a shared, programmable number of extra wait cycles to be added to long accesses in that region.

A request is sampled on a clock edge. From that edge onward the block holds `acc_active` for the whole access and reports the access length and the region. It raises `data_strobe` from the second cycle to the last one. It pulses `acc_ready` once, in the final cycle. A request that is present in the ready cycle starts the next access at once, with no idle cycle between the two.

Configuration is written through a small register port with three registers: access type, wait enable and wait count.

Top module: `wsc_top`

## Requirements
- R1: The region is `req_addr[23:21]`. Only that region's type bit and enable bit decide the length of the access, and the region is reported on `acc_region` for the whole access.
- R2: A region whose type bit is 0 has a 2-cycle access, whatever its enable bit and the wait count hold.
- R3: A region whose type bit is 1 and whose enable bit is 0 has a 3-cycle access, even when the wait count is nonzero.
- R4: A region whose type bit is 1 and whose enable bit is 1 has an access of 3 + W cycles, where W is the wait count (0 to 3).
- R5: After a synchronous reset, all outputs are low. Every type bit is 1, every enable bit is 0 and the wait count is 3.
- R6: `acc_active` is high for exactly N consecutive cycles of an access of length N. `acc_ready` is high in exactly one cycle, the N-th one.
- R7: `data_strobe` is low in the first cycle of every access and when the block is idle. It is high in cycles 2 to N.
- R8: `acc_len` equals N for the whole access.
- R9: The write select picks the register. Select 0 writes the type bits from `cfg_wdata[7:0]`, with bit r belonging to region r. Select 1 writes the enable bits in the same layout. Select 2 writes the wait count from `cfg_wdata[1:0]`. Select 3 changes nothing.
- R10: A configuration write made during an access does not change the length of that access. It applies from the next request onward.
- R11: A request is taken when the block is idle or in an `acc_ready` cycle. A request held high through `acc_ready` starts a new access in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 type, 1 enable, 2 wait count, 3 none) |
| cfg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Access request |
| req_addr | input | 24 | Access address |
| acc_active | output | 1 | High for every cycle of an access |
| acc_ready | output | 1 | One-cycle pulse in the last cycle of an access |
| data_strobe | output | 1 | Data strobe, cycles 2 to N |
| acc_len | output | 3 | Length N of the current access |
| acc_region | output | 3 | Region of the current access |

## Verification
An access is sampled on edge E0, and its cycle k lies between edge E(k-1) and edge E(k). `acc_active`, `acc_len` and `acc_region` are therefore first seen after E0. `acc_ready` is seen in cycle N, and the bus is idle in cycle N+1 unless a request was held through the ready cycle.

The bench drives its inputs on the falling edge and samples once per cycle on the falling edge, counting from cycle 1. For every cycle it compares the cycle index of each output with the N computed from the region's type bit, its enable bit and the wait count. The sweep covers every region with each type, enable and wait-count setting. In each case the other regions are set to the opposite bits, so that decoding the wrong region changes N.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    localparam int ADDR_W_DEF   = 24;
    localparam int REGION_W_DEF = 3;
    localparam int WAIT_W_DEF   = 2;

    typedef enum logic [1:0] {
        SEL_TYPE = 2'd0,
        SEL_WEN  = 2'd1,
        SEL_WAIT = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    // Length in cycles of one access, given the region's two bits and the wait count.
    function automatic logic [7:0] access_len(input logic three_state,
                                              input logic wait_on,
                                              input logic [7:0] waits);
        if (!three_state)
            return 8'd2;
        else if (wait_on)
            return 8'd3 + waits;
        else
            return 8'd3;
    endfunction

endpackage

// File: rtl/wsc_regs.sv
module wsc_regs
    import wsc_pkg::*;
#(
    parameter int NREG       = 8,
    parameter int WAIT_W     = 2,
    parameter int WAIT_RESET = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [NREG-1:0]   wdata,
    output logic [NREG-1:0]   three_state,
    output logic [NREG-1:0]   wait_en,
    output logic [WAIT_W-1:0] wait_cnt
);

    cfg_sel_e sel_e;
    assign sel_e = cfg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            three_state <= '1;
            wait_en     <= '0;
            wait_cnt    <= WAIT_W'(WAIT_RESET);
        end else if (we) begin
            case (sel_e)
                SEL_TYPE: three_state <= wdata;
                SEL_WEN:  wait_en     <= wdata;
                SEL_WAIT: wait_cnt    <= wdata[WAIT_W-1:0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/wsc_decode.sv
module wsc_decode
    import wsc_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int REGION_W = 3,
    parameter int WAIT_W   = 2,
    parameter int LEN_W    = 3
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [(1<<REGION_W)-1:0]   three_state,
    input  logic [(1<<REGION_W)-1:0]   wait_en,
    input  logic [WAIT_W-1:0]          wait_cnt,
    output logic [REGION_W-1:0]        region,
    output logic [LEN_W-1:0]           len
);

    localparam int NREG = 1 << REGION_W;

    logic [LEN_W-1:0] len_tab [NREG];
    logic             unused_offset;

    assign region        = addr[ADDR_W-1 -: REGION_W];
    assign unused_offset = ^addr[ADDR_W-REGION_W-1:0];

    for (genvar g = 0; g < NREG; g++) begin : g_region
        assign len_tab[g] = LEN_W'(access_len(three_state[g], wait_en[g], 8'(wait_cnt)));
    end

    assign len = len_tab[region];

endmodule

// File: rtl/wsc_seq.sv
module wsc_seq #(
    parameter int REGION_W = 3,
    parameter int LEN_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [REGION_W-1:0] region_in,
    input  logic [LEN_W-1:0]    len_in,
    output logic                active,
    output logic                ready,
    output logic                strobe,
    output logic [LEN_W-1:0]    len_q,
    output logic [REGION_W-1:0] region_q
);

    logic [LEN_W-1:0] cnt;
    logic             take;

    assign ready  = active && (cnt == len_q);
    assign strobe = active && (cnt >= LEN_W'(2));
    assign take   = req_valid && (!active || ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cnt      <= '0;
            len_q    <= '0;
            region_q <= '0;
        end else if (take) begin
            active   <= 1'b1;
            cnt      <= LEN_W'(1);
            len_q    <= len_in;
            region_q <= region_in;
        end else if (ready) begin
            active   <= 1'b0;
            cnt      <= '0;
            len_q    <= '0;
            region_q <= '0;
        end else if (active) begin
            cnt <= cnt + LEN_W'(1);
        end
    end

endmodule

// File: rtl/wsc_top.sv
module wsc_top
    import wsc_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int REGION_W   = REGION_W_DEF,
    parameter int WAIT_W     = WAIT_W_DEF,
    parameter int WAIT_RESET = 3,
    localparam int NREG      = 1 << REGION_W,
    localparam int LEN_W     = $clog2((1 << WAIT_W) + 3)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [NREG-1:0]     cfg_wdata,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                acc_active,
    output logic                acc_ready,
    output logic                data_strobe,
    output logic [LEN_W-1:0]    acc_len,
    output logic [REGION_W-1:0] acc_region
);

    logic [NREG-1:0]     three_state;
    logic [NREG-1:0]     wait_en;
    logic [WAIT_W-1:0]   wait_cnt;
    logic [REGION_W-1:0] dec_region;
    logic [LEN_W-1:0]    dec_len;

    wsc_regs #(.NREG(NREG), .WAIT_W(WAIT_W), .WAIT_RESET(WAIT_RESET)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .three_state(three_state), .wait_en(wait_en), .wait_cnt(wait_cnt)
    );

    wsc_decode #(.ADDR_W(ADDR_W), .REGION_W(REGION_W), .WAIT_W(WAIT_W), .LEN_W(LEN_W)) u_dec (
        .addr(req_addr), .three_state(three_state), .wait_en(wait_en),
        .wait_cnt(wait_cnt), .region(dec_region), .len(dec_len)
    );

    wsc_seq #(.REGION_W(REGION_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .region_in(dec_region),
        .len_in(dec_len), .active(acc_active), .ready(acc_ready),
        .strobe(data_strobe), .len_q(acc_len), .region_q(acc_region)
    );

endmodule

// File: rtl/wsc_chk.sv
module wsc_chk #(
    parameter int ADDR_W   = 24,
    parameter int REGION_W = 3,
    parameter int LEN_W    = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                acc_active,
    input logic                acc_ready,
    input logic                data_strobe,
    input logic [LEN_W-1:0]    acc_len,
    input logic [REGION_W-1:0] acc_region
);

    logic             taken;
    logic [LEN_W-1:0] seen;
    logic             unused_low;

    assign taken      = req_valid && (!acc_active || acc_ready);
    assign unused_low = ^req_addr[ADDR_W-REGION_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            seen <= '0;
        else if (taken)
            seen <= LEN_W'(1);
        else if (acc_ready)
            seen <= '0;
        else if (acc_active)
            seen <= seen + LEN_W'(1);
    end

    AST_READY_INSIDE: assert property (@(posedge clk) disable iff (rst) acc_ready |-> acc_active); // R6
    AST_READY_PULSE:  assert property (@(posedge clk) disable iff (rst) acc_ready |=> !acc_ready); // R6
    AST_READY_AT_END: assert property (@(posedge clk) disable iff (rst) acc_ready |-> seen == acc_len); // R6
    AST_LEN_HOLD:     assert property (@(posedge clk) disable iff (rst) acc_active && !acc_ready |=> $stable(acc_len)); // R8
    AST_LEN_RANGE:    assert property (@(posedge clk) disable iff (rst) acc_active |-> (acc_len >= LEN_W'(2)) && (acc_len <= LEN_W'(6))); // R4
    AST_STROBE_LATE:  assert property (@(posedge clk) disable iff (rst) taken |=> !data_strobe); // R7
    AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (rst) !acc_active |-> !data_strobe && !acc_ready); // R7
    AST_TAKE_START:   assert property (@(posedge clk) disable iff (rst) taken |=> acc_active); // R11
    AST_REGION_LATCH: assert property (@(posedge clk) disable iff (rst) taken |=> acc_region == $past(req_addr[ADDR_W-1 -: REGION_W])); // R1

endmodule

bind wsc_top wsc_chk #(.ADDR_W(ADDR_W), .REGION_W(REGION_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .acc_active(acc_active), .acc_ready(acc_ready), .data_strobe(data_strobe),
    .acc_len(acc_len), .acc_region(acc_region)
);

// File: tb/sim_wsc_top.sv
module sim_wsc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = 24'd0;
    logic        acc_active, acc_ready, data_strobe;
    logic [2:0]  acc_len, acc_region;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wsc_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .acc_active(acc_active),
        .acc_ready(acc_ready), .data_strobe(data_strobe), .acc_len(acc_len),
        .acc_region(acc_region)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one access; optional register write in cycle 2 (R10).
    task automatic run(input logic [23:0] addr, input int exp_n, input string tag,
                       input bit mid_wr, input logic [1:0] mid_sel, input logic [7:0] mid_data);
        int act_n = 0, rdy_n = 0, rdy_at = 0, stb_n = 0, first_len = 0, first_reg = 0;
        int stb_bad = 0, len_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= 9; k++) begin
            if (k == 1) begin first_len = acc_len; first_reg = acc_region; end
            if (acc_active) begin
                act_n++;
                if (acc_len != 3'(exp_n)) len_bad++;
            end
            if (acc_ready) begin rdy_n++; rdy_at = k; end
            if (data_strobe) begin
                stb_n++;
                if (k == 1 || k > exp_n) stb_bad++;
            end
            if (mid_wr && k == 2) begin
                cfg_we = 1'b1; cfg_sel = mid_sel; cfg_wdata = mid_data;
            end
            if (k == 3) cfg_we = 1'b0;
            @(negedge clk);
        end
        check(act_n == exp_n, {tag, " R6 active cycles"}, act_n, exp_n);
        check(rdy_n == 1 && rdy_at == exp_n, {tag, " R6 ready cycle"}, rdy_at, exp_n);
        check(stb_n == exp_n - 1 && stb_bad == 0, {tag, " R7 strobe cycles"}, stb_n, exp_n - 1);
        check(first_len == exp_n && len_bad == 0, {tag, " R8 length"}, first_len, exp_n);
        check(first_reg == int'(addr[23:21]), {tag, " R1 region"}, first_reg, int'(addr[23:21]));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!acc_active && !acc_ready && !data_strobe && acc_len == 0, "R5 idle outputs",
              {acc_active, acc_ready, data_strobe}, 0);

        // R5: defaults give 3 cycles; enabling waits uses reset wait count 3.
        run(24'hA1_2345, 3, "R5 default", 1'b0, 2'd0, 8'd0);
        wr(2'd1, 8'h20);
        run(24'hA0_0001, 6, "R5 reset wait count", 1'b0, 2'd0, 8'd0);

        // R1..R4: sweep every region, type, enable and wait count.
        for (int r = 0; r < 8; r++)
            for (int t = 0; t < 2; t++)
                for (int e = 0; e < 2; e++)
                    for (int w = 0; w < 4; w++) begin
                        logic [7:0] m;
                        int n;
                        string tag;
                        m = 8'(1 << r);
                        wr(2'd0, t != 0 ? m : ~m);
                        wr(2'd1, e != 0 ? m : ~m);
                        wr(2'd2, 8'(w) | 8'hFC);
                        n = (t == 0) ? 2 : 3 + ((e != 0) ? w : 0);
                        tag = (t == 0) ? "R2" : ((e == 0) ? "R3" : "R4");
                        run({3'(r), 21'((r * 40503 + w * 1237) & 21'h1FFFFF)}, n, tag, 1'b0, 2'd0, 8'd0);
                    end

        // R9: select 3 changes nothing.
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'd1);
        wr(2'd3, 8'h00);
        run(24'h40_0000, 4, "R9 select 3 ignored", 1'b0, 2'd0, 8'd0);

        // R10: write during an access does not change it; next access uses it.
        wr(2'd2, 8'd3);
        run(24'h00_0010, 6, "R10 in-flight", 1'b1, 2'd2, 8'd0);
        run(24'h00_0010, 3, "R10 next access", 1'b0, 2'd0, 8'd0);

        // R11: request held through ready gives back-to-back 2-cycle accesses.
        wr(2'd0, 8'h04);
        begin
            int act_n = 0, rdy_mask = 0, act_after = 0;
            @(negedge clk);
            req_valid = 1'b1; req_addr = 24'h3F_FFFF;
            @(negedge clk);
            for (int k = 1; k <= 6; k++) begin
                if (acc_active) act_n++;
                if (acc_ready) rdy_mask |= (1 << k);
                if (k == 6) req_valid = 1'b0;
                @(negedge clk);
            end
            act_after = acc_active;
            check(act_n == 6, "R11 back-to-back active", act_n, 6);
            check(rdy_mask == 'h54, "R11 ready pulses", rdy_mask, 'h54);
            check(act_after == 0, "R11 stops when request drops", act_after, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule